// File: doc/BRIEF.md
# Saturating Return-Address Stack

This block is a small last-in first-out store that holds return addresses for subroutine calls and loop linkage inside a microprogram sequencer. The surrounding sequencer decides when to save a word and when to discard one, and supplies the word to save. The stack only carries out the command it is given on each rising clock edge.

The block can hold nine words of twelve bits. Its internal pointer always addresses the most recently written word. That word is presented combinationally on the top-of-stack output, so a loop can read it on every pass without removing it. An active-low full flag and an active-high empty flag are both registered.

The edge cases are fixed in the design. Saving a word into a full stack replaces the top word and leaves the depth at nine. Removing a word from an empty stack does nothing. While the stack is empty, the top-of-stack output carries no meaning.

Top module: `ras_stack`

## Requirements
- R1: While `rst` is high at a rising edge, the stack is emptied. After that edge, `empty` is 1 and `full_n` is 1.
- R2: The `cmd` field is encoded as 0 = hold, 1 = push, 2 = pop, 3 = clear. A push writes `push_data` as the new top word. From the cycle after the edge, `tos` shows that word and `empty` is 0.
- R3: A pop removes the top word at the edge. From the next cycle, `tos` shows the word that was pushed before it, so words come back in reverse order of pushing.
- R4: A hold command leaves `tos`, `full_n` and `empty` unchanged. The top word can be read on any number of cycles without being removed.
- R5: `full_n` is low exactly when nine words are stored. It first goes low in the cycle after the ninth push, and it is high at every lower depth.
- R6: A push while nine words are stored replaces the top word with `push_data` and keeps the depth at nine. The eight words below it are not touched.
- R7: A pop while the stack is empty leaves the depth at zero and `empty` at 1. A later push and pop behave as they do on a freshly emptied stack.
- R8: A clear command empties the stack from any depth. After the edge, `empty` is 1 and `full_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; acts as a clear |
| cmd | input | 2 | Stack command: 0 hold, 1 push, 2 pop, 3 clear |
| push_data | input | 12 | Word written by a push |
| tos | output | 12 | Current top word; meaningless while empty |
| full_n | output | 1 | Low while nine words are stored |
| empty | output | 1 | High while no word is stored |

## Verification
Every command takes effect at the rising edge that samples it. The flags are registered from the next-state depth, and `tos` is a combinational read through the updated pointer. So all three results are due one cycle after the command is presented, and none is due later. The bench drives each command on the falling edge and samples the outputs shortly after the following rising edge. It compares them there with a reference stack kept in the bench, and ignores `tos` whenever that reference is empty.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_PUSH  = 2'd1,
    CMD_POP   = 2'd2,
    CMD_CLEAR = 2'd3
  } ras_cmd_e;
endpackage

// File: rtl/ras_depth_ctrl.sv
// Depth counter with saturating push, floor-clamped pop, and registered flags.
module ras_depth_ctrl #(
  parameter int DEPTH = 9,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ras_pkg::ras_cmd_e cmd,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic              full_n,
  output logic              empty
);
  logic [PW-1:0] depth_q, depth_d;
  logic          at_max, at_zero;

  assign at_max  = (depth_q == PW'(DEPTH));
  assign at_zero = (depth_q == '0);

  always_comb begin
    depth_d = depth_q;
    wr_en   = 1'b0;
    // overflow rewrites the last slot instead of moving the pointer
    wr_addr = at_max ? AW'(DEPTH - 1) : AW'(depth_q);
    if (rst || cmd == ras_pkg::CMD_CLEAR) begin
      depth_d = '0;
    end else begin
      unique case (cmd)
        ras_pkg::CMD_PUSH: begin
          wr_en = 1'b1;
          if (!at_max) depth_d = depth_q + PW'(1);
        end
        ras_pkg::CMD_POP: begin
          if (!at_zero) depth_d = depth_q - PW'(1);
        end
        default: depth_d = depth_q;
      endcase
    end
  end

  assign rd_addr = at_zero ? '0 : AW'(depth_q - PW'(1));

  always_ff @(posedge clk) begin
    depth_q <= depth_d;
    full_n  <= (depth_d != PW'(DEPTH));
    empty   <= (depth_d == '0);
  end
endmodule

// File: rtl/ras_store.sv
// Word storage: one synchronous write port, one asynchronous read port.
module ras_store #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] push_data,
  output logic [WIDTH-1:0] tos,
  output logic             full_n,
  output logic             empty
);
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;

  ras_depth_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmd     (ras_pkg::ras_cmd_e'(cmd)),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .full_n  (full_n),
    .empty   (empty)
  );

  ras_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (push_data),
    .rd_addr (rd_addr),
    .rd_data (tos)
  );
endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cmd,
  input logic [WIDTH-1:0] push_data,
  input logic [WIDTH-1:0] tos,
  input logic             full_n,
  input logic             empty
);
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      assert_reset_state_R1: assert (empty && full_n);
    end
    assert_flags_exclusive_R5: assert (!(empty && !full_n));
  end

  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == ras_pkg::CMD_PUSH) |=> (tos == $past(push_data)) && !empty);

  assert_pop_from_full_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == ras_pkg::CMD_POP && !full_n) |=> full_n);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == ras_pkg::CMD_HOLD && !empty) |=> $stable(tos) && $stable(full_n) && $stable(empty));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == ras_pkg::CMD_PUSH && !full_n) |=> !full_n);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == ras_pkg::CMD_POP && empty) |=> empty);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd == ras_pkg::CMD_CLEAR) |=> empty && full_n);
endmodule

bind ras_stack ras_stack_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .push_data (push_data),
  .tos       (tos),
  .full_n    (full_n),
  .empty     (empty)
);

// File: tb/tb_ras_stack.sv
module tb_ras_stack;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int D = 9;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   cmd;
  logic [W-1:0] push_data;
  logic [W-1:0] tos;
  logic         full_n, empty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] mdl [D];
  int depth = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_stack #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .cmd(cmd), .push_data(push_data),
    .tos(tos), .full_n(full_n), .empty(empty)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, "empty", W'(empty), W'(depth == 0));
    chk(req, "full_n", W'(full_n), W'(depth != D));
    if (depth > 0) chk(req, "tos", tos, mdl[depth-1]);
  endtask

  // drive on falling edge, sample just after the consuming rising edge
  task automatic step(input logic [1:0] c, input logic [W-1:0] d);
    @(negedge clk);
    cmd = c;
    push_data = d;
    @(posedge clk);
    #1;
    case (c)
      2'd1: begin
        if (depth < D) depth++;
        mdl[depth-1] = d;
      end
      2'd2: if (depth > 0) depth--;
      2'd3: depth = 0;
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd = 2'd0;
    @(posedge clk);
    @(posedge clk);
    #1;
    depth = 0;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check_state("R1");
  endtask

  task automatic t_lifo();
    step(2'd1, 12'h0A1); check_state("R2");
    step(2'd1, 12'h0B2); check_state("R2");
    step(2'd1, 12'h0C3); check_state("R2");
    step(2'd2, '0); check_state("R3");
    chk("R3", "tos after pop", tos, 12'h0B2);
    step(2'd2, '0); check_state("R3");
    chk("R3", "tos after pop", tos, 12'h0A1);
    step(2'd2, '0); check_state("R3");
  endtask

  task automatic t_hold();
    step(2'd1, 12'h5A5);
    for (int i = 0; i < 3; i++) begin
      step(2'd0, 12'hFFF);
      check_state("R4");
      chk("R4", "tos held", tos, 12'h5A5);
    end
    step(2'd3, '0);
  endtask

  task automatic t_full();
    for (int i = 0; i < D; i++) begin
      step(2'd1, W'(12'h100 + i));
      check_state("R5");
    end
    chk("R5", "full_n at nine", W'(full_n), '0);
    step(2'd2, '0);
    chk("R5", "full_n after pop", W'(full_n), 12'h1);
    step(2'd1, 12'h108);
    check_state("R5");
  endtask

  task automatic t_overflow();
    step(2'd1, 12'hEE1); check_state("R6");
    step(2'd1, 12'hEE2); check_state("R6");
    chk("R6", "overwritten top", tos, 12'hEE2);
    for (int i = D; i > 0; i--) begin
      step(2'd2, '0);
      check_state("R6");
    end
  endtask

  task automatic t_underflow();
    step(2'd3, '0);
    step(2'd2, '0); check_state("R7");
    step(2'd2, '0); check_state("R7");
    step(2'd1, 12'h777); check_state("R7");
    step(2'd2, '0); check_state("R7");
  endtask

  task automatic t_clear();
    for (int i = 0; i < 5; i++) step(2'd1, W'(12'h300 + i));
    step(2'd3, '0); check_state("R8");
    for (int i = 0; i < D; i++) step(2'd1, W'(12'h400 + i));
    step(2'd3, '0); check_state("R8");
    step(2'd1, 12'h321); check_state("R8");
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 4; i++) step(2'd1, W'(12'h600 + i));
    do_reset();
    check_state("R1");
  endtask

  initial begin
    rst = 1'b1;
    cmd = 2'd0;
    push_data = '0;
    t_reset();
    t_lifo();
    t_hold();
    t_full();
    t_overflow();
    t_underflow();
    t_clear();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule